// File: doc/BRIEF.md
# Directional Comparison Teleprotection Logic

This block is the scheme logic at one end of a two-ended protected line. Upstream relaying supplies four directional pickup flags: a forward overreaching trip pickup, a reverse overreaching pickup, a forward underreaching pickup and a forward overreaching permissive pickup. The block also takes the carrier signal received from the far end. It drives the carrier-send output toward the far end and the local trip output. Analog measurement, the direction decision and the channel hardware all live outside the block.

A two-bit mode input selects the scheme. In blocking mode the block sends a block signal while it sees a reverse fault. It trips on a forward pickup only after a settable coordination window, typically 30 to 40 ms, has passed with no block seen at any point. A received block is stretched by a settable hold time, so a current reversal cannot open a window for a false trip. Blocking mode needs no weak-end-infeed logic, because the strong end trips when no block arrives. In the two permissive modes the carrier-send output follows the matching forward pickup, and a trip needs both the forward pickup and the received carrier.

All timing counts ticks of an external millisecond-rate enable. Both outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge.

Top module: `dircomp_scheme`

## Requirements
- R1: With mode 2'b00 (blocking), `send_o` equals `rev_pu_i` sampled at the previous clock edge.
- R2: In blocking mode, a `fwd_trip_pu_i` held high with no block seen raises `trip_o` in the cycle after the tick that brings the coordination count to `coord_ms_i`. The count rises by one per `tick_ms_i` cycle. `trip_o` stays high while these conditions hold, and not one tick earlier.
- R3: In blocking mode, the coordination count returns to zero and `trip_o` falls in the next cycle whenever `fwd_trip_pu_i` drops or a block is seen.
- R4: A block counts as seen while `rx_carrier_i` is high and for `hold_ms_i` further ticks after it falls. The hold count reloads while the carrier is high and only decrements on ticks. No blocking-mode trip occurs while a block is seen.
- R5: With mode 2'b01 (permissive underreach), `send_o` follows `fwd_ur_pu_i` with one cycle of latency. The reverse pickup and the overreach permissive pickup have no effect on it.
- R6: With mode 2'b10 (permissive overreach), `send_o` follows `fwd_or_pu_i` with one cycle of latency. The underreach and reverse pickups have no effect on it.
- R7: In modes 2'b01 and 2'b10, `trip_o` equals `fwd_trip_pu_i AND rx_carrier_i` from the previous edge, with no delay and no effect from the hold count.
- R8: With mode 2'b11 (disabled), both `send_o` and `trip_o` are low one cycle later, whatever the other inputs are.
- R9: A synchronous active-high `rst_i` clears both timers and drives `send_o` and `trip_o` low at the next edge.
- R10: In blocking mode with `coord_ms_i` equal to zero and no block seen, a forward pickup trips in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_ms_i | input | 1 | One-cycle millisecond tick enable |
| mode_i | input | 2 | Scheme select: 00 blocking, 01 permissive underreach, 10 permissive overreach, 11 disabled |
| fwd_trip_pu_i | input | 1 | Forward overreaching trip pickup |
| rev_pu_i | input | 1 | Reverse overreaching pickup |
| fwd_ur_pu_i | input | 1 | Forward underreaching pickup |
| fwd_or_pu_i | input | 1 | Forward overreaching permissive pickup |
| rx_carrier_i | input | 1 | Carrier received from the far end |
| coord_ms_i | input | CNT_W | Coordination window in ticks |
| hold_ms_i | input | CNT_W | Received-block hold time in ticks |
| send_o | output | 1 | Carrier send toward the far end |
| trip_o | output | 1 | Local trip |

## Verification
A hold counter that decrements early or reloads wrongly shows up as a forward fault that trips one tick too soon after a carrier pulse. It appears at `trip_o` in the cycle right after the miscounted tick. A coordination count that fails to clear on a block shows up as a trip inside the next window after the block ends. A wrong mode decode moves `send_o` to the wrong pickup on the first cycle after the mode changes. The bench therefore steps ticks one at a time and compares both outputs on every cycle, including windows of 35 and 40 ticks that are checked tick by tick.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [1:0] {
        MODE_BLOCK = 2'b00,
        MODE_PUR   = 2'b01,
        MODE_POR   = 2'b10,
        MODE_OFF   = 2'b11
    } dcs_mode_e;

    typedef struct packed {
        logic send;
        logic trip;
    } dcs_out_t;

endpackage

// File: rtl/dcs_block_hold.sv
module dcs_block_hold #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_ms_i,
    input  logic             rx_i,
    input  logic [CNT_W-1:0] hold_ms_i,
    output logic             block_o
);

    logic [CNT_W-1:0] hold_d, hold_q;

    // Reload while carrier present; drain one per tick afterwards.
    always_comb begin
        hold_d = hold_q;
        if (rx_i) begin
            hold_d = hold_ms_i;
        end else if (tick_ms_i && (hold_q != '0)) begin
            hold_d = hold_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) hold_q <= '0;
        else       hold_q <= hold_d;
    end

    assign block_o = rx_i || (hold_q != '0);

endmodule

// File: rtl/dcs_coord_timer.sv
module dcs_coord_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_ms_i,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] coord_ms_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Counts ticks while armed, saturating at the setting; any disarm clears.
    always_comb begin
        cnt_d = '0;
        if (arm_i) begin
            cnt_d = cnt_q;
            if (tick_ms_i && (cnt_q < coord_ms_i)) begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign expired_o = arm_i && (cnt_d >= coord_ms_i);

endmodule

// File: rtl/dcs_send_sel.sv
module dcs_send_sel
    import dcs_pkg::*;
(
    input  dcs_mode_e mode_i,
    input  logic      rev_pu_i,
    input  logic      fwd_ur_pu_i,
    input  logic      fwd_or_pu_i,
    output logic      send_o
);

    always_comb begin
        unique case (mode_i)
            MODE_BLOCK: send_o = rev_pu_i;
            MODE_PUR:   send_o = fwd_ur_pu_i;
            MODE_POR:   send_o = fwd_or_pu_i;
            default:    send_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dircomp_scheme.sv
module dircomp_scheme
    import dcs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_ms_i,
    input  logic [1:0]       mode_i,
    input  logic             fwd_trip_pu_i,
    input  logic             rev_pu_i,
    input  logic             fwd_ur_pu_i,
    input  logic             fwd_or_pu_i,
    input  logic             rx_carrier_i,
    input  logic [CNT_W-1:0] coord_ms_i,
    input  logic [CNT_W-1:0] hold_ms_i,
    output logic             send_o,
    output logic             trip_o
);

    dcs_mode_e mode;
    logic      block_seen;
    logic      coord_arm;
    logic      coord_expired;
    logic      send_next;
    dcs_out_t  out_d, out_q;

    assign mode = dcs_mode_e'(mode_i);

    dcs_block_hold #(.CNT_W(CNT_W)) u_hold (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_ms_i (tick_ms_i),
        .rx_i      (rx_carrier_i),
        .hold_ms_i (hold_ms_i),
        .block_o   (block_seen)
    );

    assign coord_arm = (mode == MODE_BLOCK) && fwd_trip_pu_i && !block_seen;

    dcs_coord_timer #(.CNT_W(CNT_W)) u_coord (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_ms_i  (tick_ms_i),
        .arm_i      (coord_arm),
        .coord_ms_i (coord_ms_i),
        .expired_o  (coord_expired)
    );

    dcs_send_sel u_send (
        .mode_i      (mode),
        .rev_pu_i    (rev_pu_i),
        .fwd_ur_pu_i (fwd_ur_pu_i),
        .fwd_or_pu_i (fwd_or_pu_i),
        .send_o      (send_next)
    );

    always_comb begin
        out_d.send = send_next;
        unique case (mode)
            MODE_BLOCK:         out_d.trip = coord_expired;
            MODE_PUR, MODE_POR: out_d.trip = fwd_trip_pu_i && rx_carrier_i;
            default:            out_d.trip = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) out_q <= '0;
        else       out_q <= out_d;
    end

    assign send_o = out_q.send;
    assign trip_o = out_q.trip;

endmodule

// File: rtl/dircomp_scheme_chk.sv
module dircomp_scheme_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             tick_ms_i,
    input logic [1:0]       mode_i,
    input logic             fwd_trip_pu_i,
    input logic             rev_pu_i,
    input logic             fwd_ur_pu_i,
    input logic             fwd_or_pu_i,
    input logic             rx_carrier_i,
    input logic [CNT_W-1:0] coord_ms_i,
    input logic [CNT_W-1:0] hold_ms_i,
    input logic             send_o,
    input logic             trip_o
);

    assert_block_send_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b00) |=> (send_o == $past(rev_pu_i)));

    assert_no_fwd_no_trip_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b00 && !fwd_trip_pu_i) |=> !trip_o);

    assert_rx_blocks_trip_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b00 && rx_carrier_i) |=> !trip_o);

    assert_pur_send_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b01) |=> (send_o == $past(fwd_ur_pu_i)));

    assert_por_send_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b10) |=> (send_o == $past(fwd_or_pu_i)));

    assert_perm_trip_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b01 || mode_i == 2'b10)
            |=> (trip_o == $past(fwd_trip_pu_i && rx_carrier_i)));

    assert_off_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b11) |=> (!send_o && !trip_o));

    assert_reset_clears_R9: assert property (@(posedge clk_i)
        rst_i |=> (!send_o && !trip_o));

endmodule

bind dircomp_scheme dircomp_scheme_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .tick_ms_i     (tick_ms_i),
    .mode_i        (mode_i),
    .fwd_trip_pu_i (fwd_trip_pu_i),
    .rev_pu_i      (rev_pu_i),
    .fwd_ur_pu_i   (fwd_ur_pu_i),
    .fwd_or_pu_i   (fwd_or_pu_i),
    .rx_carrier_i  (rx_carrier_i),
    .coord_ms_i    (coord_ms_i),
    .hold_ms_i     (hold_ms_i),
    .send_o        (send_o),
    .trip_o        (trip_o)
);

// File: tb/sim_dircomp_scheme.sv
`timescale 1ns/1ps
module sim_dircomp_scheme;

    localparam int CNT_W = 16;
    localparam int NVEC  = 32;

    logic             clk = 1'b0;
    logic             rst;
    logic             tick;
    logic [1:0]       mode;
    logic             fwd, rev, ur, orp, rx;
    logic [CNT_W-1:0] coord, hold;
    logic             send, trip;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dircomp_scheme #(.CNT_W(CNT_W)) u0 (
        .clk_i(clk), .rst_i(rst), .tick_ms_i(tick), .mode_i(mode),
        .fwd_trip_pu_i(fwd), .rev_pu_i(rev), .fwd_ur_pu_i(ur),
        .fwd_or_pu_i(orp), .rx_carrier_i(rx),
        .coord_ms_i(coord), .hold_ms_i(hold),
        .send_o(send), .trip_o(trip)
    );

    // {mode[1:0], fwd, rev, ur, or, rx, tick, exp_send, exp_trip}, coord=3 hold=2
    localparam logic [9:0] VEC [NVEC] = '{
        10'b00_0100_00_10, // R1 reverse pickup sends block
        10'b00_0000_00_00, // R1
        10'b00_1000_00_00, // R2 no tick yet
        10'b00_1000_01_00, // R2 count 1
        10'b00_1000_01_00, // R2 count 2
        10'b00_1000_01_01, // R2 count 3 trips
        10'b00_1000_00_01, // R2 stays tripped
        10'b00_0000_00_00, // R3 forward drops
        10'b00_1000_01_00, // R3 restart count 1
        10'b00_1000_11_00, // R4 carrier received
        10'b00_1000_01_00, // R4 hold 2
        10'b00_1000_01_00, // R4 hold 1
        10'b00_1000_01_00, // R4 hold over, count 1
        10'b00_1000_01_00, // R4 count 2
        10'b00_1000_01_01, // R4 count 3 trips
        10'b00_1000_10_00, // R4 block during trip
        10'b00_1000_00_00, // R4 hold without tick
        10'b00_0000_00_00, // R4
        10'b00_0000_01_00, // R4 drain
        10'b00_0000_01_00, // R4 drain
        10'b01_0010_00_10, // R5 underreach sends
        10'b01_0110_00_10, // R5 reverse ignored
        10'b01_0001_00_00, // R5 overreach ignored
        10'b01_1000_00_00, // R7 no carrier
        10'b01_1000_10_01, // R7 forward and carrier
        10'b01_1000_00_00, // R7 hold ignored
        10'b10_0001_00_10, // R6 overreach sends
        10'b10_0010_00_00, // R6 underreach ignored
        10'b10_1000_10_01, // R7
        10'b10_0100_00_00, // R6 reverse ignored
        10'b11_1111_11_00, // R8 disabled
        10'b00_1000_01_00  // R4 hold still loaded
    };
    localparam int VREQ [NVEC] = '{1,1,2,2,2,2,2,3,3,4,4,4,4,4,4,4,4,4,4,4,
                                   5,5,5,7,7,7,6,6,7,6,8,4};

    task automatic check(input string req, input logic es, input logic et);
        n_chk++;
        if (send !== es || trip !== et) begin
            n_fail++;
            $display("FAIL %s: send=%b trip=%b expected send=%b trip=%b",
                     req, send, trip, es, et);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        tick = 0; fwd = 0; rev = 0; ur = 0; orp = 0; rx = 0; mode = 2'b00;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst = 1; coord = 16'd3; hold = 16'd2;
        step(); step();
        check("R9", 1'b0, 1'b0);
        rst = 0;

        for (int i = 0; i < NVEC; i++) begin
            mode = VEC[i][9:8];
            fwd  = VEC[i][7]; rev = VEC[i][6]; ur = VEC[i][5]; orp = VEC[i][4];
            rx   = VEC[i][3]; tick = VEC[i][2];
            step();
            check($sformatf("R%0d row %0d", VREQ[i], i), VEC[i][1], VEC[i][0]);
        end

        // R9: reset with active pickups clears outputs
        clear_in(); rev = 1; fwd = 1; rst = 1;
        step();
        check("R9 reset with pickups", 1'b0, 1'b0);
        rst = 0; rev = 0;

        // R10: zero coordination trips next cycle
        coord = 16'd0;
        step();
        check("R10 zero window", 1'b0, 1'b1);

        // R9: reset mid-trip
        rst = 1;
        step();
        check("R9 reset mid-trip", 1'b0, 1'b0);
        rst = 0;

        // R2: 35-tick window, trip exactly on the 35th tick
        coord = 16'd35; fwd = 1; tick = 1;
        for (int k = 1; k <= 35; k++) begin
            step();
            if (k < 35) check("R2 long window early", 1'b0, 1'b0);
            else        check("R2 long window expiry", 1'b0, 1'b1);
        end
        tick = 0;

        // R4: 40-tick hold blocks a zero-window trip for 40 ticks
        coord = 16'd0; hold = 16'd40; rx = 1;
        step();
        check("R4 carrier present", 1'b0, 1'b0);
        rx = 0; tick = 1;
        for (int k = 0; k < 40; k++) begin
            step();
            check("R4 long hold", 1'b0, 1'b0);
        end
        step();
        check("R4 hold expired", 1'b0, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule